// File: doc/BRIEF.md
# Trace Branch Address Reassembler

This block decodes a stream of captured pipeline-trace words, one word per clock. Each 20-bit word carries a 3-bit pipeline status, a 16-bit packet field and a sync marker. The decoder reports the effective status class of every word and flags trigger cycles. It keeps a running instruction address that moves forward by four on every executed word. When a branch is traced, the decoder also rebuilds the branch target from the address packets that follow the branch in the stream.

The target arrives as 7-bit groups with a continuation bit. These groups are taken from the two byte halves of the packet field, low half first. A 4-bit skip count tells the decoder where the first group is. That count is carried in the two words that follow the branch, so the decoder looks two words ahead. The block reports how many address bits are known. It pulses a strobe when a target is complete, and it reports a branch reason when a target uses the full five groups. Downstream logic can use the outputs directly to annotate a trace.

Top module: `trace_branch_decoder`

## Requirements
- R1: Word layout is status in bits [2:0], packet field in bits [18:3] and sync marker in bit 19. The status codes are 0 executed, 1 data access, 2 not executed, 3 wait, 4 branch, 5 branch with data, 6 trigger and 7 trace off. `cls` reports the effective status. For a trigger word (code 6) this is packet bits [2:0]; for any other word it is the status field.
- R2: `trig` is 1 exactly for words whose status field is 6.
- R3: A word whose effective status has its low two bits unequal to 3 is an executed word. It adds 4 to the address, after any group writes made by that same word.
- R4: When a word's effective status is 4, the next word supplies skip-count bits [1:0] and the word after it supplies bits [3:2]. Each bit pair is taken from status bits [1:0], or from packet bits [1:0] when that word is a trigger word.
- R5: If either of the two words after a branch has status field 4 or 5, the branch is dropped. No search starts for it.
- R6: The search begins with the word after the branch. The decoder first passes over as many sync-marked words as the skip count gives. The first group is then taken from the next word that has its sync marker set and a valid packet field.
- R7: The packet field is used only when the status field is neither 6 nor 7. Inside a word, the low byte is used before the high byte. Once the first group is found, every later word with a valid field supplies groups, whether or not it has a sync marker.
- R8: Group k (k = 0..4) comes from byte bits [6:0]. It overwrites address bits [7k+6:7k], truncated at bit 31. Byte bit 7 set means another group follows. A target never uses more than 5 groups.
- R9: When a target completes with n groups, `vbits` becomes the larger of its old value and min(7n, 32). It never decreases.
- R10: When a target completes with 5 groups, `rsn_vld` pulses together with `br_vld`, and `rsn` carries bits [6:4] of the fifth byte.
- R11: `addr_known` is 1 exactly when `vbits` is nonzero.
- R12: `br_vld` is high for exactly the one word on which a target completes.
- R13: After reset, all outputs are zero. The result for the word sampled at a clock edge appears after the third edge counted from that one, and `out_vld` marks such results.
- R14: A branch that starts a search cancels any search still in progress, without a strobe. Groups that were already written stay in the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_word | input | 20 | Captured trace word, one per cycle |
| out_vld | output | 1 | Outputs belong to a word sampled after reset |
| cls | output | 3 | Effective pipeline status of the word |
| trig | output | 1 | Word was a trigger cycle |
| addr | output | 32 | Tracked instruction address after this word |
| addr_known | output | 1 | At least one address group is known |
| vbits | output | 6 | Count of known address bits |
| br_vld | output | 1 | Branch target completed on this word |
| rsn | output | 3 | Branch reason code (0 normal, 1 trace on, 2 overflow restart, 3 debug exit, 4 periodic sync) |
| rsn_vld | output | 1 | `rsn` is valid |

## Verification
The assertions check properties that must hold on every cycle. `br_vld` is never high on two cycles in a row. `vbits` never decreases and only takes legal values. `addr_known` rises only together with a completion strobe. A reason strobe appears only on a completion with all 32 bits known. Skip-count extraction, abandoned branches, trigger substitution, byte-half order and search cancellation only show in the address value and in the timing of the strobe. Only the bench's directed segments and its random streams, compared against a word-by-word reference model, can show them.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

    localparam int TW_W     = 20;
    localparam int ST_W     = 3;
    localparam int PKT_W    = 16;
    localparam int SKIP_W   = 4;
    localparam int RSN_W    = 3;
    localparam int RSN_LSB  = 4;

    typedef enum logic [ST_W-1:0] {
        PS_EXEC   = 3'd0,
        PS_DATA   = 3'd1,
        PS_NOEXEC = 3'd2,
        PS_WAIT   = 3'd3,
        PS_BRANCH = 3'd4,
        PS_BRDATA = 3'd5,
        PS_TRIG   = 3'd6,
        PS_OFF    = 3'd7
    } pstat_e;

    // bit layout of a captured word: {sync, packet, status}
    typedef struct packed {
        logic             sync;
        logic [PKT_W-1:0] pkt;
        logic [ST_W-1:0]  st;
    } tword_s;

    localparam tword_s IDLE_WORD = '{sync: 1'b0, pkt: '0, st: 3'd7};

    function automatic logic st_is_trig(input logic [ST_W-1:0] st);
        return st == PS_TRIG;
    endfunction

    function automatic pstat_e eff_status(input logic [ST_W-1:0] st,
                                          input logic [ST_W-1:0] pkt_lo);
        return st_is_trig(st) ? pstat_e'(pkt_lo) : pstat_e'(st);
    endfunction

    function automatic logic field_ok(input logic [ST_W-1:0] st);
        return (st != PS_TRIG) && (st != PS_OFF);
    endfunction

    function automatic logic is_exec(input pstat_e s);
        return s[1:0] != 2'b11;
    endfunction

    function automatic logic is_any_branch(input logic [ST_W-1:0] st);
        return (st == PS_BRANCH) || (st == PS_BRDATA);
    endfunction

    function automatic logic [1:0] skip_pair(input logic [ST_W-1:0] st,
                                             input logic [1:0] pkt_lo);
        return st_is_trig(st) ? pkt_lo : st[1:0];
    endfunction

endpackage

// File: rtl/tbd_lookahead.sv
module tbd_lookahead
    import tbd_pkg::*;
#(
    parameter int LA_DEPTH = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  tword_s in_word,
    output tword_s cur_word,
    output tword_s next_word,
    output logic   cur_vld
);
    tword_s pipe [LA_DEPTH];
    logic   vpipe [LA_DEPTH];

    genvar g;
    generate
        for (g = 0; g < LA_DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) begin
                        pipe[g]  <= IDLE_WORD;
                        vpipe[g] <= 1'b0;
                    end else begin
                        pipe[g]  <= in_word;
                        vpipe[g] <= 1'b1;
                    end
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) begin
                        pipe[g]  <= IDLE_WORD;
                        vpipe[g] <= 1'b0;
                    end else begin
                        pipe[g]  <= pipe[g-1];
                        vpipe[g] <= vpipe[g-1];
                    end
                end
            end
        end
    endgenerate

    assign cur_word  = pipe[LA_DEPTH-1];
    assign next_word = pipe[LA_DEPTH-2];
    assign cur_vld   = vpipe[LA_DEPTH-1];
endmodule

// File: rtl/tbd_arm.sv
module tbd_arm
    import tbd_pkg::*;
(
    input  pstat_e            cur_eff,
    input  logic [ST_W-1:0]   la1_st,
    input  logic [1:0]        la1_lo,
    input  logic [ST_W-1:0]   la2_st,
    input  logic [1:0]        la2_lo,
    output logic              start,
    output logic [SKIP_W-1:0] skip
);
    logic dropped;

    always_comb begin
        dropped = is_any_branch(la1_st) || is_any_branch(la2_st);
        start   = (cur_eff == PS_BRANCH) && !dropped;
        skip    = {skip_pair(la2_st, la2_lo), skip_pair(la1_st, la1_lo)};
    end
endmodule

// File: rtl/tbd_gather.sv
module tbd_gather
    import tbd_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int GRP_W   = 7,
    parameter int PKT_MAX = 5,
    parameter int CNT_W   = $clog2(PKT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SKIP_W-1:0] start_skip,
    input  logic              sync,
    input  logic              pkt_ok,
    input  logic [PKT_W-1:0]  pkt,
    output logic [ADDR_W-1:0] mmask,
    output logic [ADDR_W-1:0] mval,
    output logic              done,
    output logic [CNT_W-1:0]  done_cnt,
    output logic [RSN_W-1:0]  done_rsn
);
    typedef enum logic [1:0] {G_IDLE, G_SKIP, G_HUNT, G_COLLECT} gst_e;

    gst_e              st_q, st_d;
    logic [SKIP_W-1:0] skip_q, skip_d;
    logic [CNT_W-1:0]  pk_q, pk_d;
    logic [7:0]        b0, b1;
    logic              take;
    int                c1, c2;

    function automatic logic [ADDR_W-1:0] gmask(input int k);
        return {{(ADDR_W-GRP_W){1'b0}}, {GRP_W{1'b1}}} << (k * GRP_W);
    endfunction

    function automatic logic [ADDR_W-1:0] gval(input int k, input logic [7:0] b);
        return {{(ADDR_W-GRP_W){1'b0}}, b[GRP_W-1:0]} << (k * GRP_W);
    endfunction

    always_comb begin
        st_d     = st_q;
        skip_d   = skip_q;
        pk_d     = pk_q;
        mmask    = '0;
        mval     = '0;
        done     = 1'b0;
        done_cnt = pk_q;
        done_rsn = '0;
        b0       = pkt[7:0];
        b1       = pkt[15:8];
        c1       = int'(pk_q) + 1;
        c2       = int'(pk_q) + 2;
        take     = pkt_ok && ((st_q == G_COLLECT) || (st_q == G_HUNT && sync));
        if (start) begin
            st_d   = (start_skip == '0) ? G_HUNT : G_SKIP;
            skip_d = start_skip;
            pk_d   = '0;
        end else if (st_q == G_SKIP) begin
            if (sync) begin
                skip_d = skip_q - 1'b1;
                if (skip_q == SKIP_W'(1)) st_d = G_HUNT;
            end
        end else if (take) begin
            mmask = gmask(int'(pk_q));
            mval  = gval(int'(pk_q), b0);
            if (b0[7] && c1 < PKT_MAX) begin
                mmask = mmask | gmask(c1);
                mval  = mval | gval(c1, b1);
                if (b1[7] && c2 < PKT_MAX) begin
                    st_d = G_COLLECT;
                    pk_d = CNT_W'(c2);
                end else begin
                    st_d     = G_IDLE;
                    done     = 1'b1;
                    done_cnt = CNT_W'(c2);
                    done_rsn = b1[RSN_LSB +: RSN_W];
                end
            end else begin
                st_d     = G_IDLE;
                done     = 1'b1;
                done_cnt = CNT_W'(c1);
                done_rsn = b0[RSN_LSB +: RSN_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= G_IDLE;
            skip_q <= '0;
            pk_q   <= '0;
        end else begin
            st_q   <= st_d;
            skip_q <= skip_d;
            pk_q   <= pk_d;
        end
    end
endmodule

// File: rtl/trace_branch_decoder.sv
module trace_branch_decoder
    import tbd_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int GRP_W   = 7,
    parameter int PKT_MAX = 5,
    localparam int VB_W   = $clog2(ADDR_W + 1),
    localparam int CNT_W  = $clog2(PKT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TW_W-1:0]   trace_word,
    output logic              out_vld,
    output logic [ST_W-1:0]   cls,
    output logic              trig,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_known,
    output logic [VB_W-1:0]   vbits,
    output logic              br_vld,
    output logic [RSN_W-1:0]  rsn,
    output logic              rsn_vld
);
    tword_s            la2, la1, cur;
    logic              cur_vld;
    pstat_e            eff;
    logic              start;
    logic [SKIP_W-1:0] skip;
    logic [ADDR_W-1:0] mmask, mval, addr_nx;
    logic              done;
    logic [CNT_W-1:0]  done_cnt;
    logic [RSN_W-1:0]  done_rsn;
    logic [VB_W-1:0]   vb_nx;
    int                grant;
    logic              unused_la1;

    assign la2        = tword_s'(trace_word);
    assign unused_la1 = ^{la1.sync, la1.pkt[PKT_W-1:2]};
    assign eff        = eff_status(cur.st, cur.pkt[ST_W-1:0]);

    tbd_lookahead #(.LA_DEPTH(2)) u_la (
        .clk       (clk),
        .rst       (rst),
        .in_word   (la2),
        .cur_word  (cur),
        .next_word (la1),
        .cur_vld   (cur_vld)
    );

    tbd_arm u_arm (
        .cur_eff (eff),
        .la1_st  (la1.st),
        .la1_lo  (la1.pkt[1:0]),
        .la2_st  (la2.st),
        .la2_lo  (la2.pkt[1:0]),
        .start   (start),
        .skip    (skip)
    );

    tbd_gather #(
        .ADDR_W  (ADDR_W),
        .GRP_W   (GRP_W),
        .PKT_MAX (PKT_MAX),
        .CNT_W   (CNT_W)
    ) u_gather (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_skip (skip),
        .sync       (cur.sync),
        .pkt_ok     (field_ok(cur.st)),
        .pkt        (cur.pkt),
        .mmask      (mmask),
        .mval       (mval),
        .done       (done),
        .done_cnt   (done_cnt),
        .done_rsn   (done_rsn)
    );

    always_comb begin
        addr_nx = (addr & ~mmask) | (mval & mmask);
        if (is_exec(eff)) addr_nx = addr_nx + ADDR_W'(4);
        grant = GRP_W * int'(done_cnt);
        if (grant > ADDR_W) grant = ADDR_W;
        vb_nx = vbits;
        if (done && grant > int'(vbits)) vb_nx = VB_W'(grant);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld    <= 1'b0;
            cls        <= '0;
            trig       <= 1'b0;
            addr       <= '0;
            addr_known <= 1'b0;
            vbits      <= '0;
            br_vld     <= 1'b0;
            rsn        <= '0;
            rsn_vld    <= 1'b0;
        end else begin
            out_vld    <= cur_vld;
            cls        <= eff;
            trig       <= st_is_trig(cur.st);
            addr       <= addr_nx;
            vbits      <= vb_nx;
            addr_known <= vb_nx != '0;
            br_vld     <= done;
            rsn_vld    <= done && (done_cnt == CNT_W'(PKT_MAX));
            rsn        <= (done && done_cnt == CNT_W'(PKT_MAX)) ? done_rsn : '0;
        end
    end
endmodule

// File: rtl/tbd_checker.sv
module tbd_checker #(
    parameter int ADDR_W = 32,
    parameter int GRP_W  = 7,
    parameter int VB_W   = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            out_vld,
    input logic            trig,
    input logic            addr_known,
    input logic [VB_W-1:0] vbits,
    input logic            br_vld,
    input logic            rsn_vld
);
    // R12
    br_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        br_vld |=> !br_vld);

    // R9
    vbits_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> int'(vbits) >= int'($past(vbits)));

    // R9
    vbits_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(vbits) % GRP_W == 0 && int'(vbits) <= ADDR_W) || int'(vbits) == ADDR_W);

    // R11
    known_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_known) |-> br_vld);

    // R10
    rsn_full_chk: assert property (@(posedge clk) disable iff (rst)
        rsn_vld |-> br_vld && int'(vbits) == ADDR_W);

    // R13
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> !br_vld && !addr_known && !trig);
endmodule

bind trace_branch_decoder tbd_checker #(
    .ADDR_W (ADDR_W),
    .GRP_W  (GRP_W),
    .VB_W   (VB_W)
) u_tbd_chk (
    .clk        (clk),
    .rst        (rst),
    .out_vld    (out_vld),
    .trig       (trig),
    .addr_known (addr_known),
    .vbits      (vbits),
    .br_vld     (br_vld),
    .rsn_vld    (rsn_vld)
);

// File: tb/test_trace_branch_decoder.sv
module test_trace_branch_decoder;
    localparam int NW = 2048;
    localparam logic [19:0] TD_WORD = 20'h00007;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] trace_word = TD_WORD;
    logic        out_vld, trig, addr_known, br_vld, rsn_vld;
    logic [2:0]  cls, rsn;
    logic [31:0] addr;
    logic [5:0]  vbits;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [19:0] wv [NW];
    string       tg [NW];
    int          n = 0;

    logic [2:0]  e_cls [NW];
    logic        e_trig [NW];
    logic [31:0] e_addr [NW];
    int          e_vb [NW];
    logic        e_br [NW];
    logic        e_rv [NW];
    logic [2:0]  e_rs [NW];

    always #5 clk = ~clk;

    trace_branch_decoder i_trace_branch_decoder (
        .clk        (clk),
        .rst        (rst),
        .trace_word (trace_word),
        .out_vld    (out_vld),
        .cls        (cls),
        .trig       (trig),
        .addr       (addr),
        .addr_known (addr_known),
        .vbits      (vbits),
        .br_vld     (br_vld),
        .rsn        (rsn),
        .rsn_vld    (rsn_vld)
    );

    function automatic logic [19:0] mk(input logic sy, input logic [15:0] p, input logic [2:0] s);
        return {sy, p, s};
    endfunction

    function automatic logic [1:0] pair_of(input logic [19:0] w);
        return (w[2:0] == 3'd6) ? w[4:3] : w[1:0];
    endfunction

    function automatic logic br_like(input logic [19:0] w);
        return w[2:0] == 3'd4 || w[2:0] == 3'd5;
    endfunction

    task automatic push(input logic [19:0] w, input string t);
        wv[n] = w;
        tg[n] = t;
        n++;
    endtask

    task automatic chk(input logic ok, input string req, input string what, input int i,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s word %0d actual=%0h expected=%0h", req, what, i, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic build_expected();
        int mst = 0, mskip = 0, mpk = 0, vb = 0;
        logic [31:0] a = '0;
        for (int i = 0; i < n; i++) begin
            logic [19:0] w, l1, l2;
            logic [2:0]  raw, eff, rs;
            logic [15:0] p;
            logic        sy, ok, bv, rv;
            w = wv[i]; raw = w[2:0]; p = w[18:3]; sy = w[19];
            eff = (raw == 3'd6) ? p[2:0] : raw;
            ok  = raw < 3'd6;
            l1  = (i + 1 < n) ? wv[i+1] : TD_WORD;
            l2  = (i + 2 < n) ? wv[i+2] : TD_WORD;
            bv = 0; rv = 0; rs = 0;
            if (eff == 3'd4 && !br_like(l1) && !br_like(l2)) begin
                mskip = int'({pair_of(l2), pair_of(l1)});
                mst   = (mskip == 0) ? 2 : 1;
                mpk   = 0;
            end else if (mst == 1) begin
                if (sy) begin
                    mskip--;
                    if (mskip == 0) mst = 2;
                end
            end else if (mst >= 2 && ok && (mst == 3 || sy)) begin
                for (int h = 0; h < 2; h++) begin
                    logic [7:0] b;
                    int t;
                    b = (h == 0) ? p[7:0] : p[15:8];
                    a = (a & ~(32'h7F << (7 * mpk))) | ({25'b0, b[6:0]} << (7 * mpk));
                    mpk++;
                    if (!(b[7] && mpk < 5)) begin
                        bv = 1;
                        t = (7 * mpk > 32) ? 32 : 7 * mpk;
                        if (t > vb) vb = t;
                        if (mpk == 5) begin
                            rv = 1;
                            rs = b[6:4];
                        end
                        mst = 0;
                        break;
                    end
                    if (h == 1) mst = 3;
                end
            end
            if (eff[1:0] != 2'b11) a = a + 32'd4;
            e_cls[i] = eff; e_trig[i] = (raw == 3'd6); e_addr[i] = a; e_vb[i] = vb;
            e_br[i] = bv; e_rv[i] = rv; e_rs[i] = rs;
        end
    endtask

    task automatic build_stream();
        // plain executed, data, skipped, wait words
        push(mk(0, 16'h0000, 3'd0), "R3");
        push(mk(0, 16'h1234, 3'd1), "R3");
        push(mk(0, 16'h0000, 3'd3), "R3");
        push(mk(0, 16'h0000, 3'd2), "R3");
        // branch, skip 0, two groups from a sync word
        push(mk(0, 16'h0000, 3'd4), "R6");
        push(mk(0, 16'h0000, 3'd0), "R6");
        push(mk(0, 16'h0000, 3'd0), "R6");
        push(mk(0, 16'h0000, 3'd3), "R6");
        push(mk(1, 16'h2295, 3'd0), "R6");
        push(mk(0, 16'h0000, 3'd0), "R6");
        // branch, skip 1, invalid fields skipped, five groups with reason 3
        push(mk(0, 16'h0000, 3'd4), "R8");
        push(mk(0, 16'h0000, 3'd1), "R8");
        push(mk(0, 16'h0000, 3'd0), "R8");
        push(mk(1, 16'hFFFF, 3'd3), "R8");
        push(mk(1, 16'h5555, 3'd7), "R7");
        push(mk(1, 16'h8281, 3'd0), "R8");
        push(mk(0, 16'hFFF8, 3'd6), "R7");
        push(mk(0, 16'h8483, 3'd2), "R8");
        push(mk(0, 16'h003A, 3'd0), "R10");
        push(mk(0, 16'h0000, 3'd3), "R10");
        // trigger in the first follow-up word supplies skip bits 10
        push(mk(0, 16'h0000, 3'd4), "R4");
        push(mk(0, 16'h0002, 3'd6), "R4");
        push(mk(0, 16'h0000, 3'd0), "R4");
        push(mk(1, 16'h0000, 3'd3), "R4");
        push(mk(1, 16'h0000, 3'd3), "R4");
        push(mk(1, 16'h0011, 3'd0), "R4");
        push(mk(0, 16'h0000, 3'd3), "R4");
        // dropped branches
        push(mk(0, 16'h0000, 3'd4), "R5");
        push(mk(0, 16'h0000, 3'd5), "R5");
        push(mk(1, 16'h0055, 3'd0), "R5");
        push(mk(0, 16'h0000, 3'd4), "R5");
        push(mk(0, 16'h0000, 3'd0), "R5");
        push(mk(0, 16'h0000, 3'd4), "R5");
        push(mk(0, 16'h0000, 3'd3), "R5");
        push(mk(1, 16'h0000, 3'd1), "R5");
        push(mk(1, 16'h0066, 3'd0), "R5");
        push(mk(0, 16'h0000, 3'd3), "R5");
        // new branch cancels a search in progress
        push(mk(0, 16'h0000, 3'd4), "R14");
        push(mk(0, 16'h0000, 3'd0), "R14");
        push(mk(0, 16'h0000, 3'd0), "R14");
        push(mk(1, 16'h8080, 3'd0), "R14");
        push(mk(0, 16'h0000, 3'd4), "R14");
        push(mk(0, 16'h0000, 3'd1), "R14");
        push(mk(0, 16'h0000, 3'd0), "R14");
        push(mk(1, 16'h0000, 3'd0), "R14");
        push(mk(1, 16'h0007, 3'd0), "R14");
        push(mk(0, 16'h0000, 3'd3), "R14");
        // random traffic
        while (n < 1600) begin
            logic [2:0]  s;
            logic [15:0] p;
            logic        sy;
            s  = 3'($urandom_range(0, 7));
            p  = 16'($urandom);
            sy = ($urandom_range(0, 3) == 0);
            push(mk(sy, p, s), "R8");
        end
    endtask

    initial begin
        void'($urandom(32'd20240613));
        build_stream();
        build_expected();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < n + 3; c++) begin
            // outputs visible now were registered at the previous edge
            if (c < 3) begin
                chk(out_vld == 1'b0, "R13", "out_vld", c, 32'(out_vld), 0);
                if (c == 0) begin
                    chk(addr == 32'd0, "R13", "reset addr", c, addr, 0);
                    chk(vbits == 6'd0, "R13", "reset vbits", c, 32'(vbits), 0);
                    chk(br_vld == 1'b0, "R13", "reset br_vld", c, 32'(br_vld), 0);
                end
            end else begin
                int i;
                i = c - 3;
                chk(out_vld == 1'b1, "R13", "out_vld", i, 32'(out_vld), 1);
                chk(cls == e_cls[i], "R1", "cls", i, 32'(cls), 32'(e_cls[i]));
                chk(trig == e_trig[i], "R2", "trig", i, 32'(trig), 32'(e_trig[i]));
                chk(addr == e_addr[i], {"R3 ", tg[i]}, "addr", i, addr, e_addr[i]);
                chk(int'(vbits) == e_vb[i], "R9", "vbits", i, 32'(vbits), 32'(e_vb[i]));
                chk(addr_known == (e_vb[i] != 0), "R11", "addr_known", i,
                    32'(addr_known), 32'(e_vb[i] != 0));
                chk(br_vld == e_br[i], {"R12 ", tg[i]}, "br_vld", i, 32'(br_vld), 32'(e_br[i]));
                chk(rsn_vld == e_rv[i], "R10", "rsn_vld", i, 32'(rsn_vld), 32'(e_rv[i]));
                chk(rsn == e_rs[i], "R10", "rsn", i, 32'(rsn), 32'(e_rs[i]));
            end
            trace_word = (c < n) ? wv[c] : TD_WORD;
            @(negedge clk);
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule